// File: doc/BRIEF.md
# Indexed RTC Register Port

This block is the register file of a real-time clock as seen from a byte-wide bus. Software reaches it through two ports. One port, selected by address bit 0 = 0, holds a register pointer. The other port, selected by address bit 0 = 1, reads or writes whichever register that pointer names. The block keeps seven calendar fields: seconds, minutes, hours, weekday, day of month, month and two-digit year. It also keeps a control byte, a status byte and an event byte, plus a small scratch array. The fields are held in BCD or in plain binary, chosen per instance by a parameter.

A one-second strobe on `sec_tick` starts an update. A small sequencer with three states drives it:
- `SEQ_IDLE` moves to `SEQ_LEAD` on a tick while the freeze bit is clear.
- `SEQ_LEAD` counts `UIP_LEAD` clocks and then moves to `SEQ_APPLY`.
- `SEQ_APPLY` performs the calendar increment at its closing edge and returns to `SEQ_IDLE`.

Both `SEQ_LEAD` and `SEQ_APPLY` fall back to `SEQ_IDLE` at once if the freeze bit becomes set. The busy flag is high in every state other than `SEQ_IDLE`. Each completed update raises two event flags, which a read of the event byte clears.

Top module: `rtc_index_port`

Register pointer values:

| Pointer | Register |
|---|---|
| 0 | seconds |
| 2 | minutes |
| 4 | hours |
| 6 | weekday |
| 7 | day of month |
| 8 | month |
| 9 | year |
| 10 | status byte (A) |
| 11 | control byte (B) |
| 12 | event byte (C) |
| 13 | valid byte (D) |
| 14 to 14+RAM_WORDS-1 | scratch |

Any other pointer reads 0 and ignores writes.

## Requirements
- R1: A bus write with `addr0`=0 loads `wdata` into the 8-bit register pointer. While `addr0`=0, `rdata` shows the pointer.
- R2: A bus write with `addr0`=1 stores `wdata` into the register the pointer names. While `addr0`=1, `rdata` shows that register. This applies to the calendar fields and to the scratch words at pointers 14 and up.
- R3: With `BCD_MODE`=1, fields are packed BCD (tens in bits 7:4, ones in bits 3:0), so seconds 0x09 step to 0x10. In this mode bit 2 of register 11 reads 0.
- R4: With `BCD_MODE`=0, fields are plain binary and bit 2 of register 11 reads 1.
- R5: Each update adds one second. Seconds and minutes wrap from 59 to 0 and carry. Hours wrap from 23 to 0 and carry into the day.
- R6: Register 13 always reads 0x80 (bit 7 = valid), and writes to it have no effect.
- R7: While bit 7 (freeze) of register 11 is 1, ticks are ignored: the busy flag stays 0, no event flags are raised, and the calendar keeps the values written.
- R8: Bit 7 of register 10 (busy) reads 1 from the clock after a tick for exactly `UIP_LEAD`+1 clocks. The calendar changes at the edge where busy falls.
- R9: A completed update sets bit 7 and bit 4 of register 12 (0x90). A read of register 12 returns its value and then clears it, and writes to it are ignored. An update arriving in the same cycle as that read leaves 0x90.
- R10: On a day carry, the weekday steps 1 to 7 and then back to 1. When the day of month wraps, the month steps; it wraps from 12 to 1 and carries into the year, which wraps from 99 to 0.
- R11: The day of month wraps after 31, 30 or 28 days as the month demands. February has 29 days when the year is divisible by 4.
- R12: A software write to a calendar field in the update cycle wins for that field, and the other fields still update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Bus access strobe, one cycle per access |
| wr | input | 1 | 1 = write, 0 = read |
| addr0 | input | 1 | 0 = pointer port, 1 = data port |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current `addr0` and pointer |
| sec_tick | input | 1 | One-cycle pulse once per second |

## Verification
Two functions can land on the same clock edge: the sequencer's increment in `SEQ_APPLY`, and a software access through the data port. The bench counts `UIP_LEAD` clocks after a tick and then drives a data-port access in exactly the `SEQ_APPLY` cycle. In one run the access is a write to seconds, which must win over the increment while minutes keep their value. In another run the access is a read of the event byte: it must return the old value, and the flags set by the update must remain for the next read.

// File: rtl/rtcp_pkg.sv
package rtcp_pkg;

    localparam logic [7:0] IX_SEC  = 8'd0;
    localparam logic [7:0] IX_MIN  = 8'd2;
    localparam logic [7:0] IX_HOUR = 8'd4;
    localparam logic [7:0] IX_WDAY = 8'd6;
    localparam logic [7:0] IX_MDAY = 8'd7;
    localparam logic [7:0] IX_MON  = 8'd8;
    localparam logic [7:0] IX_YEAR = 8'd9;
    localparam logic [7:0] IX_STAT = 8'd10;
    localparam logic [7:0] IX_CTRL = 8'd11;
    localparam logic [7:0] IX_EVT  = 8'd12;
    localparam logic [7:0] IX_VLD  = 8'd13;
    localparam int         N_FIELDS = 7;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_LEAD,
        SEQ_APPLY
    } seq_state_t;

    typedef logic [N_FIELDS-1:0][7:0] cal_t;

    // slot k of the calendar vector -> register pointer
    function automatic logic [7:0] field_index(input int k);
        case (k)
            0:       return IX_SEC;
            1:       return IX_MIN;
            2:       return IX_HOUR;
            3:       return IX_WDAY;
            4:       return IX_MDAY;
            5:       return IX_MON;
            default: return IX_YEAR;
        endcase
    endfunction

    function automatic logic [7:0] field_reset(input int k);
        return (k >= 3 && k <= 5) ? 8'd1 : 8'd0;
    endfunction

    function automatic logic [7:0] enc_to_bin(input logic [7:0] v, input bit bcd);
        return bcd ? ({4'd0, v[7:4]} * 8'd10 + {4'd0, v[3:0]}) : v;
    endfunction

    function automatic logic [7:0] bin_to_enc(input logic [7:0] v, input bit bcd);
        logic [7:0] tens;
        logic [7:0] ones;
        tens = v / 8'd10;
        ones = v % 8'd10;
        return bcd ? {tens[3:0], ones[3:0]} : v;
    endfunction

    function automatic logic [7:0] days_in_month(input logic [7:0] m, input logic [7:0] y);
        case (m)
            8'd2:                     return (y[1:0] == 2'b00) ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11: return 8'd30;
            default:                  return 8'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_cal_step.sv
module rtc_cal_step
    import rtcp_pkg::*;
#(
    parameter bit BCD_MODE = 1'b1
) (
    input  cal_t cur,
    output cal_t nxt
);

    cal_t       b;
    cal_t       n;
    logic [7:0] mdays;
    logic       c_sec, c_min, c_hour, c_day, c_mon;

    always_comb begin
        for (int k = 0; k < N_FIELDS; k++) begin
            b[k] = enc_to_bin(cur[k], BCD_MODE);
        end
        n     = b;
        mdays = days_in_month(b[5], b[6]);

        c_sec  = (b[0] >= 8'd59);
        n[0]   = c_sec ? 8'd0 : b[0] + 8'd1;

        c_min  = c_sec && (b[1] >= 8'd59);
        if (c_sec) n[1] = (b[1] >= 8'd59) ? 8'd0 : b[1] + 8'd1;

        c_hour = c_min && (b[2] >= 8'd23);
        if (c_min) n[2] = (b[2] >= 8'd23) ? 8'd0 : b[2] + 8'd1;

        c_day  = c_hour && (b[4] >= mdays);
        if (c_hour) begin
            n[3] = (b[3] >= 8'd7) ? 8'd1 : b[3] + 8'd1;
            n[4] = (b[4] >= mdays) ? 8'd1 : b[4] + 8'd1;
        end

        c_mon  = c_day && (b[5] >= 8'd12);
        if (c_day) n[5] = (b[5] >= 8'd12) ? 8'd1 : b[5] + 8'd1;
        if (c_mon) n[6] = (b[6] >= 8'd99) ? 8'd0 : b[6] + 8'd1;

        for (int k = 0; k < N_FIELDS; k++) begin
            nxt[k] = bin_to_enc(n[k], BCD_MODE);
        end
    end

endmodule

// File: rtl/rtc_uip_seq.sv
module rtc_uip_seq
    import rtcp_pkg::*;
#(
    parameter int UIP_LEAD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic freeze,
    output logic uip,
    output logic fire
);

    localparam int               CW   = $clog2(UIP_LEAD + 1);
    localparam logic [CW-1:0]    LAST = CW'(UIP_LEAD - 1);

    seq_state_t    st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            SEQ_IDLE: begin
                cnt_d = '0;
                if (tick && !freeze) st_d = SEQ_LEAD;
            end
            SEQ_LEAD: begin
                if (freeze)              st_d = SEQ_IDLE;
                else if (cnt_q == LAST)  st_d = SEQ_APPLY;
                else                     cnt_d = cnt_q + 1'b1;
            end
            SEQ_APPLY: st_d = SEQ_IDLE;
            default:   st_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= SEQ_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        uip  = (st_q != SEQ_IDLE);
        fire = (st_q == SEQ_APPLY) && !freeze;
    end

endmodule

// File: rtl/rtc_index_port.sv
module rtc_index_port
    import rtcp_pkg::*;
#(
    parameter bit BCD_MODE  = 1'b1,
    parameter int UIP_LEAD  = 4,
    parameter int RAM_WORDS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel,
    input  logic       wr,
    input  logic       addr0,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       sec_tick
);

    localparam int RAM_BASE = 14;

    logic [7:0] idx_q;
    cal_t       time_q, time_nx;
    logic [6:0] stat_low_q;
    logic [7:0] ctrl_q;
    logic       uf_q, irqf_q;
    logic [7:0] ram_q [RAM_WORDS];
    logic       uip, fire, set_q;
    logic [7:0] sec_q;
    logic       wr_idx, wr_dat, rd_evt;

    assign set_q  = ctrl_q[7];
    assign sec_q  = time_q[0];
    assign wr_idx = sel && wr && !addr0;
    assign wr_dat = sel && wr && addr0;
    assign rd_evt = sel && !wr && addr0 && (idx_q == IX_EVT);

    rtc_uip_seq #(.UIP_LEAD(UIP_LEAD)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (sec_tick),
        .freeze (set_q),
        .uip    (uip),
        .fire   (fire)
    );

    rtc_cal_step #(.BCD_MODE(BCD_MODE)) u_step (
        .cur (time_q),
        .nxt (time_nx)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q      <= '0;
            stat_low_q <= '0;
            ctrl_q     <= '0;
            uf_q       <= 1'b0;
            irqf_q     <= 1'b0;
            for (int k = 0; k < N_FIELDS; k++) time_q[k] <= field_reset(k);
            for (int j = 0; j < RAM_WORDS; j++) ram_q[j] <= '0;
        end else begin
            if (wr_idx) idx_q <= wdata;
            if (wr_dat && idx_q == IX_STAT) stat_low_q <= wdata[6:0];
            if (wr_dat && idx_q == IX_CTRL) ctrl_q     <= wdata;
            // an update outranks the read-clear of the event byte
            if (fire) begin
                uf_q   <= 1'b1;
                irqf_q <= 1'b1;
            end else if (rd_evt) begin
                uf_q   <= 1'b0;
                irqf_q <= 1'b0;
            end
            // a software write outranks the increment, field by field
            for (int k = 0; k < N_FIELDS; k++) begin
                if (wr_dat && idx_q == field_index(k)) time_q[k] <= wdata;
                else if (fire)                          time_q[k] <= time_nx[k];
            end
            for (int j = 0; j < RAM_WORDS; j++) begin
                if (wr_dat && idx_q == 8'(RAM_BASE + j)) ram_q[j] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (!addr0) begin
            rdata = idx_q;
        end else begin
            case (idx_q)
                IX_STAT: rdata = {uip, stat_low_q};
                IX_CTRL: rdata = {ctrl_q[7:3], ~BCD_MODE, ctrl_q[1:0]};
                IX_EVT:  rdata = {irqf_q, 2'b00, uf_q, 4'b0000};
                IX_VLD:  rdata = 8'h80;
                default: rdata = '0;
            endcase
            for (int k = 0; k < N_FIELDS; k++) begin
                if (idx_q == field_index(k)) rdata = time_q[k];
            end
            for (int j = 0; j < RAM_WORDS; j++) begin
                if (idx_q == 8'(RAM_BASE + j)) rdata = ram_q[j];
            end
        end
    end

endmodule

// File: rtl/rtc_index_port_chk.sv
module rtc_index_port_chk
    import rtcp_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       sel,
    input logic       wr,
    input logic       addr0,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic       sec_tick,
    input logic       uip,
    input logic       fire,
    input logic       set_q,
    input logic [7:0] idx_q,
    input logic [7:0] sec_q
);

    a_r1_index_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr && !addr0) |=> (idx_q == $past(wdata)));

    a_r6_valid_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (addr0 && idx_q == IX_VLD) |-> (rdata == 8'h80));

    a_r8_uip_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(uip) |-> $past(sec_tick));

    a_r8_fire_in_uip: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> uip);

    a_r8_uip_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(uip) |-> ($past(fire) || $past(set_q)));

    a_r7_frozen_sec: assert property (@(posedge clk) disable iff (!rst_n)
        (set_q && !(sel && wr && addr0)) |=> $stable(sec_q));

    a_r7_no_fire_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        set_q |-> !fire);

endmodule

bind rtc_index_port rtc_index_port_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (sel),
    .wr       (wr),
    .addr0    (addr0),
    .wdata    (wdata),
    .rdata    (rdata),
    .sec_tick (sec_tick),
    .uip      (uip),
    .fire     (fire),
    .set_q    (set_q),
    .idx_q    (idx_q),
    .sec_q    (sec_q)
);

// File: tb/sim_rtc_index_port.sv
module sim_rtc_index_port;

    localparam int L = 4;

    logic       clk = 1'b0;
    logic       rst_n, sel, wr, addr0, sec_tick;
    logic [7:0] wdata, rdata0, rdata1;
    int         n_chk = 0;
    int         n_err = 0;
    int         mt [7];

    always #10 clk = ~clk;

    rtc_index_port #(.BCD_MODE(1'b1), .UIP_LEAD(L), .RAM_WORDS(8)) u0 (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .addr0(addr0),
        .wdata(wdata), .rdata(rdata0), .sec_tick(sec_tick));

    rtc_index_port #(.BCD_MODE(1'b0), .UIP_LEAD(L), .RAM_WORDS(8)) u1 (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .addr0(addr0),
        .wdata(wdata), .rdata(rdata1), .sec_tick(sec_tick));

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s actual=%02h expected=%02h", req, got, exp);
        end
    endtask

    task automatic bus(input logic w, input logic a, input logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; wr = w; addr0 = a; wdata = d;
        @(posedge clk);
        #1 sel = 1'b0;
    endtask

    task automatic rd(input int idx, output logic [7:0] r0, output logic [7:0] r1);
        bus(1'b1, 1'b0, 8'(idx));
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr0 = 1'b1;
        #1 r0 = rdata0; r1 = rdata1;
        @(posedge clk);
        #1 sel = 1'b0;
    endtask

    task automatic wreg(input int idx, input logic [7:0] v);
        bus(1'b1, 1'b0, 8'(idx));
        bus(1'b1, 1'b1, v);
    endtask

    function automatic logic [7:0] enc(input int v, input bit bcd);
        return bcd ? 8'(((v / 10) << 4) | (v % 10)) : 8'(v);
    endfunction

    function automatic int fidx(input int k);
        case (k)
            0: return 0;  1: return 2;  2: return 4;  3: return 6;
            4: return 7;  5: return 8;  default: return 9;
        endcase
    endfunction

    function automatic int mdays(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    // expected calendar after one second, from the requirements
    function automatic void model_step();
        mt[0]++;
        if (mt[0] < 60) return;
        mt[0] = 0; mt[1]++;
        if (mt[1] < 60) return;
        mt[1] = 0; mt[2]++;
        if (mt[2] < 24) return;
        mt[2] = 0;
        mt[3] = (mt[3] == 7) ? 1 : mt[3] + 1;
        mt[4]++;
        if (mt[4] <= mdays(mt[5], mt[6])) return;
        mt[4] = 1; mt[5]++;
        if (mt[5] <= 12) return;
        mt[5] = 1;
        mt[6] = (mt[6] == 99) ? 0 : mt[6] + 1;
    endfunction

    task automatic set_time(input bit bcd);
        for (int k = 0; k < 7; k++) wreg(fidx(k), enc(mt[k], bcd));
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        sec_tick = 1'b1;
        @(posedge clk);
        #1 sec_tick = 1'b0;
    endtask

    task automatic do_tick();
        pulse_tick();
        repeat (L + 3) @(negedge clk);
    endtask

    task automatic check_all(input bit use_u1, input string tag);
        logic [7:0] r0, r1;
        for (int k = 0; k < 7; k++) begin
            rd(fidx(k), r0, r1);
            if (use_u1) chk(tag, r1, enc(mt[k], 1'b0));
            else        chk(tag, r0, enc(mt[k], 1'b1));
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] r0, r1;
        int         hi_first, hi_last, lo_after, seen;
        void'($urandom(32'd5150));
        rst_n = 1'b0; sel = 1'b0; wr = 1'b0; addr0 = 1'b0;
        wdata = '0; sec_tick = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // reset state
        rd(0, r0, r1);  chk("R2 reset seconds", r0, 8'h00);
        rd(6, r0, r1);  chk("R10 reset weekday", r0, 8'h01);
        rd(12, r0, r1); chk("R9 reset event byte", r0, 8'h00);
        rd(10, r0, r1); chk("R8 reset status byte", r0, 8'h00);
        rd(11, r0, r1); chk("R3 BCD mode flag", r0, 8'h00);
        chk("R4 binary mode flag", r1, 8'h04);

        // pointer port
        bus(1'b1, 1'b0, 8'h2A);
        @(negedge clk); addr0 = 1'b0; #1 chk("R1 pointer readback", rdata0, 8'h2A);

        // scratch word and valid byte
        wreg(17, 8'hA5);
        rd(17, r0, r1); chk("R2 scratch word", r0, 8'hA5);
        wreg(13, 8'h00);
        rd(13, r0, r1); chk("R6 valid byte after write", r0, 8'h80);

        // BCD low-nibble carry
        mt = '{9, 0, 0, 1, 1, 1, 0};
        set_time(1'b1); do_tick(); model_step();
        rd(0, r0, r1); chk("R3 BCD carry 09->10", r0, 8'h10);

        // busy window and event flags
        rd(12, r0, r1);
        bus(1'b1, 1'b0, 8'(10));
        @(negedge clk); addr0 = 1'b1;
        pulse_tick();
        hi_first = 0; hi_last = 0; lo_after = 1;
        for (int i = 1; i <= L + 2; i++) begin
            @(negedge clk); #1;
            if (i == 1)     hi_first = int'(rdata0[7]);
            if (i == L + 1) hi_last  = int'(rdata0[7]);
            if (i == L + 2) lo_after = int'(rdata0[7]);
        end
        chk("R8 busy after tick", 8'(hi_first), 8'd1);
        chk("R8 busy last cycle", 8'(hi_last), 8'd1);
        chk("R8 busy cleared", 8'(lo_after), 8'd0);
        rd(12, r0, r1); chk("R9 flags set by update", r0, 8'h90);
        rd(12, r0, r1); chk("R9 flags cleared by read", r0, 8'h00);
        wreg(12, 8'hFF);
        rd(12, r0, r1); chk("R9 write ignored", r0, 8'h00);

        // freeze
        wreg(11, 8'h80);
        wreg(0, 8'h33);
        bus(1'b1, 1'b0, 8'(10));
        @(negedge clk); addr0 = 1'b1;
        pulse_tick();
        seen = 0;
        for (int i = 1; i <= L + 2; i++) begin
            @(negedge clk); #1;
            if (rdata0[7]) seen = 1;
        end
        chk("R7 busy stays low", 8'(seen), 8'd0);
        rd(0, r0, r1);  chk("R7 seconds frozen", r0, 8'h33);
        rd(12, r0, r1); chk("R7 no flags while frozen", r0, 8'h00);
        wreg(11, 8'h00);

        // leap February, non-leap February, year roll
        mt = '{59, 59, 23, 3, 28, 2, 24};
        set_time(1'b1); do_tick(); model_step(); check_all(1'b0, "R11 leap February");
        mt = '{59, 59, 23, 3, 28, 2, 23};
        set_time(1'b1); do_tick(); model_step(); check_all(1'b0, "R11 plain February");
        mt = '{59, 59, 23, 7, 31, 12, 99};
        set_time(1'b1); do_tick(); model_step(); check_all(1'b0, "R10 year and weekday wrap");

        // binary instance full carry
        mt = '{59, 59, 23, 7, 30, 4, 50};
        set_time(1'b0); do_tick(); model_step(); check_all(1'b1, "R4 R5 binary carry");

        // software write in the update cycle
        mt = '{12, 5, 10, 1, 1, 1, 20};
        set_time(1'b1);
        rd(12, r0, r1);
        bus(1'b1, 1'b0, 8'(0));
        pulse_tick();
        repeat (L) @(negedge clk);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr0 = 1'b1; wdata = 8'h30;
        @(posedge clk); #1 sel = 1'b0;
        repeat (2) @(negedge clk);
        rd(0, r0, r1); chk("R12 write wins", r0, 8'h30);
        rd(2, r0, r1); chk("R12 minutes kept", r0, 8'h05);

        // event read in the update cycle
        rd(12, r0, r1); chk("R9 flags before race", r0, 8'h90);
        bus(1'b1, 1'b0, 8'(12));
        pulse_tick();
        repeat (L) @(negedge clk);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr0 = 1'b1;
        #1 chk("R9 read in update cycle", rdata0, 8'h00);
        @(posedge clk); #1 sel = 1'b0;
        repeat (2) @(negedge clk);
        rd(12, r0, r1); chk("R9 set wins over clear", r0, 8'h90);

        // constrained random calendars
        for (int it = 0; it < 30; it++) begin
            mt[0] = ($urandom % 3 == 0) ? 59 : int'($urandom % 60);
            mt[1] = ($urandom % 2 == 0) ? 59 : int'($urandom % 60);
            mt[2] = ($urandom % 2 == 0) ? 23 : int'($urandom % 24);
            mt[3] = 1 + int'($urandom % 7);
            mt[5] = 1 + int'($urandom % 12);
            mt[6] = int'($urandom % 100);
            mt[4] = ($urandom % 2 == 0) ? mdays(mt[5], mt[6])
                                        : 1 + int'($urandom % 28);
            set_time(1'b1); do_tick(); model_step();
            check_all(1'b0, "R5 R10 R11 random step");
        end

        finish_run();
    end

endmodule